// File: doc/BRIEF.md
# Passive serial configuration sequencer

This block loads a configuration image into a target programmable device over a two-wire passive serial link. A start command drives the active-low configuration request pin low for a fixed reset pulse. The block then checks that the target's active-low status pin shows the reset, releases the request, and polls the status pin at fixed microsecond intervals until the target reports that it is ready. After a settling delay it shifts the image out, least significant bit first, on a data line with a clock line. At the end it checks the status and done pins and sends one trailing all-zero byte, which gives the target the extra clocks it needs to start up.

The image arrives as a valid/ready byte stream with a last flag. The timing set is chosen per start through a profile select. Profile 0 has a short maximum status wait and a short settle delay; profile 1 has longer ones. A per-start flag bit-reverses every byte for images that are stored most significant bit first. The outcome is reported on a done flag and a 3-bit error code. Both hold their value until the next start. All microsecond delays come from a prescaler derived from a clocks-per-microsecond parameter.

Top module: `ps_cfg_seq`

## Requirements
- R1: On an accepted start, `tgt_cfg_n_o` goes low for exactly RST_US microseconds (RST_US*CYC_US clock cycles). It is high whenever the block is idle.
- R2: If `tgt_stat_n_i` is not low at the end of the reset pulse, the block returns to idle with error code 2. It produces no serial clock edge.
- R3: After the request is released, the status pin is sampled every POLL_US microseconds, up to ceil(MAXW/POLL_US) times. MAXW is MAXW_A for profile 0 and MAXW_B for profile 1. If every sample sees the pin low, error code 3 is set and busy drops in the cycle after the final sample.
- R4: When a sample sees the status pin high, the block waits SET_A (profile 0) or SET_B (profile 1) microseconds. The first rising serial clock edge then follows 1+SCK_HALF cycles later, provided a byte is offered.
- R5: Each byte goes out least significant bit first. When `msb_first_i` was set at start, every byte is bit-reversed before shifting. `s_ready_o` is high only while the serial clock is low.
- R6: The serial clock stays high for exactly SCK_HALF cycles at each pulse. The data line does not change while the clock is high.
- R7: If the status pin is low after the last byte, the block ends with error code 4 and sends no trailing clocks.
- R8: With DONE_CHECK nonzero, a low `tgt_done_i` after the last byte ends the run with error code 5 and sends no trailing clocks.
- R9: Otherwise the block shifts eight extra clocks with the data line at 0, then raises `done_o` with error code 0.
- R10: A start with `partial_i` high is rejected with error code 1. The pins stay idle and busy stays low.
- R11: The error code and done flag hold while idle. Any start, accepted or rejected, clears `done_o`, and an accepted start clears the error code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| partial_i | input | 1 | Start is a partial reconfiguration request |
| profile_i | input | 1 | Timing profile select (0 or 1) |
| msb_first_i | input | 1 | Image bytes are stored MSB first; reverse them |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Stream byte is the last of the image |
| s_ready_o | output | 1 | Block takes a byte on this cycle if valid |
| tgt_stat_n_i | input | 1 | Target status, active low, asynchronous |
| tgt_done_i | input | 1 | Target configuration done, asynchronous |
| tgt_cfg_n_o | output | 1 | Configuration request to target, active low |
| sdata_o | output | 1 | Serial data to target |
| sclk_o | output | 1 | Serial clock to target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run completed successfully |
| err_o | output | 3 | Error code of the last run (0 none) |

## Verification
Every result has a due cycle that follows from the parameters. The request pulse lasts RST_US*CYC_US cycles. Busy drops in the cycle after the final status sample, POLL_US*CYC_US cycles per sample after the request is released. The first clock rise comes j*POLL_US*CYC_US + SET*CYC_US + 1 + SCK_HALF cycles after release, where j is the first sample that sees the pin high. The bench samples outputs on the falling edge and stamps each event with a cycle index. It compares differences of these indices with the formula and compares the bits captured at each clock rise with a queue built from the offered bytes. The error code and done flag are read once busy has dropped, and again one cycle after the next start.

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq #(
  parameter int CYC_US     = 50,
  parameter int RST_US     = 2,
  parameter int POLL_US    = 268,
  parameter int MAXW_A     = 1506,
  parameter int MAXW_B     = 3000,
  parameter int SET_A      = 2,
  parameter int SET_B      = 10,
  parameter int SCK_HALF   = 2,
  parameter int DONE_CHECK = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic       profile_i,
  input  logic       msb_first_i,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       tgt_stat_n_i,
  input  logic       tgt_done_i,
  output logic       tgt_cfg_n_o,
  output logic       sdata_o,
  output logic       sclk_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] err_o
);

  localparam int NPOLL_A = (MAXW_A + POLL_US - 1) / POLL_US;
  localparam int NPOLL_B = (MAXW_B + POLL_US - 1) / POLL_US;
  localparam int NMAX    = NPOLL_A > NPOLL_B ? NPOLL_A : NPOLL_B;
  localparam int L1      = RST_US > POLL_US ? RST_US : POLL_US;
  localparam int L2      = SET_A > SET_B ? SET_A : SET_B;
  localparam int LONG    = L1 > L2 ? L1 : L2;
  localparam int TW      = $clog2(LONG + 1);
  localparam int NW      = $clog2(NMAX + 1);
  localparam int PW      = CYC_US > 1 ? $clog2(CYC_US) : 1;
  localparam int DW      = SCK_HALF > 1 ? $clog2(SCK_HALF) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_WAIT, S_SET, S_LOAD, S_SHIFT, S_CHK
  } st_t;

  st_t st, st_nx;
  logic [PW-1:0] pre;
  logic [TW-1:0] tmr;
  logic [NW-1:0] polls;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic nst_m, nst_s, dn_m, dn_s;
  logic prof_q, msb_q, last_q, trail_q, sclk_q, done_q;
  logic [2:0] err_q;

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = b[7-k];
    return r;
  endfunction

  wire tick       = pre == PW'(CYC_US - 1);
  wire rst_exp    = tick && tmr == TW'(RST_US - 1);
  wire poll_exp   = tick && tmr == TW'(POLL_US - 1);
  wire set_exp    = tick && tmr == (prof_q ? TW'(SET_B - 1) : TW'(SET_A - 1));
  wire poll_last  = polls == (prof_q ? NW'(NPOLL_B - 1) : NW'(NPOLL_A - 1));
  wire half_end   = div == DW'(SCK_HALF - 1);
  wire bit_end    = half_end && sclk_q && bitn == 3'd7;
  wire done_bad   = (DONE_CHECK != 0) && !dn_s;

  assign tgt_cfg_n_o = st != S_RST;
  assign sdata_o     = sh[0];
  assign sclk_o      = sclk_q;
  assign busy_o      = st != S_IDLE;
  assign s_ready_o   = st == S_LOAD;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start_i && !partial_i) st_nx = S_RST;
      S_RST:   if (rst_exp) st_nx = nst_s ? S_IDLE : S_WAIT;
      S_WAIT:  if (poll_exp) begin
                 if (nst_s) st_nx = S_SET;
                 else if (poll_last) st_nx = S_IDLE;
               end
      S_SET:   if (set_exp) st_nx = S_LOAD;
      S_LOAD:  if (s_valid_i) st_nx = S_SHIFT;
      S_SHIFT: if (bit_end) st_nx = trail_q ? S_IDLE : (last_q ? S_CHK : S_LOAD);
      S_CHK:   st_nx = (!nst_s || done_bad) ? S_IDLE : S_SHIFT;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      tmr <= '0;
    end else if (st_nx != st || (st == S_WAIT && poll_exp)) begin
      pre <= '0;
      tmr <= '0;
    end else if (tick) begin
      pre <= '0;
      tmr <= tmr + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nst_m <= 1'b1;
      nst_s <= 1'b1;
      dn_m  <= 1'b0;
      dn_s  <= 1'b0;
    end else begin
      nst_m <= tgt_stat_n_i;
      nst_s <= nst_m;
      dn_m  <= tgt_done_i;
      dn_s  <= dn_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      polls   <= '0;
      div     <= '0;
      bitn    <= '0;
      sh      <= '0;
      prof_q  <= 1'b0;
      msb_q   <= 1'b0;
      last_q  <= 1'b0;
      trail_q <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 3'd0;
    end else begin
      st <= st_nx;
      case (st)
        S_IDLE: if (start_i) begin
          err_q   <= partial_i ? 3'd1 : 3'd0;
          done_q  <= 1'b0;
          prof_q  <= profile_i;
          msb_q   <= msb_first_i;
          polls   <= '0;
          trail_q <= 1'b0;
        end
        S_RST: if (rst_exp && nst_s) err_q <= 3'd2;
        S_WAIT: if (poll_exp && !nst_s) begin
          if (poll_last) err_q <= 3'd3;
          else polls <= polls + 1'b1;
        end
        S_LOAD: if (s_valid_i) begin
          sh     <= msb_q ? flip(s_data_i) : s_data_i;
          last_q <= s_last_i;
          bitn   <= 3'd0;
          div    <= '0;
        end
        S_SHIFT: begin
          if (half_end) begin
            div    <= '0;
            sclk_q <= !sclk_q;
            if (sclk_q && bitn != 3'd7) begin
              bitn <= bitn + 1'b1;
              sh   <= sh >> 1;
            end
            if (bit_end && trail_q) done_q <= 1'b1;
          end else begin
            div <= div + 1'b1;
          end
        end
        S_CHK: begin
          if (!nst_s) err_q <= 3'd4;
          else if (done_bad) err_q <= 3'd5;
          else begin
            sh      <= 8'h00;
            trail_q <= 1'b1;
            bitn    <= 3'd0;
            div     <= '0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module ps_cfg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       s_ready_o,
  input logic       tgt_cfg_n_o,
  input logic       sdata_o,
  input logic       sclk_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] err_o
);

  p_no_clk_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_cfg_n_o |-> !sclk_o) else $error("clock edge during request pulse");

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (tgt_cfg_n_o && !sclk_o && !s_ready_o)) else $error("pin activity while idle");

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)) else $error("data moved with clock high");

  p_ready_clock_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> !sclk_o) else $error("byte taken with clock high");

  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy_o) && !$past(start_i)) |-> $stable(err_o)) else $error("error code moved while idle");

  p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> err_o == 3'd0) else $error("done with error code");

endmodule

bind ps_cfg_seq ps_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_ready_o(s_ready_o),
  .tgt_cfg_n_o(tgt_cfg_n_o), .sdata_o(sdata_o), .sclk_o(sclk_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/ps_cfg_seq_tb.sv
module ps_cfg_seq_tb;
  localparam int CLK_NS = 10;
  localparam int CYC_US = 3, RST_US = 2, POLL_US = 8, MAXW_A = 20, MAXW_B = 40;
  localparam int SET_A = 2, SET_B = 5, SCK_HALF = 2;
  localparam int LIMIT = 150000;
  localparam int M_REL = 0, M_NEVER = 1, M_STUCK = 2, M_CERR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, partial = 0, profile = 0, msbf = 0;
  logic s_valid = 0, s_last = 0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, stat_n, done_pin = 0;
  logic cfg_n, sdata, sclk, busy, done_f;
  logic [2:0] err;

  always #(CLK_NS/2) clk = ~clk;

  ps_cfg_seq #(.CYC_US(CYC_US), .RST_US(RST_US), .POLL_US(POLL_US), .MAXW_A(MAXW_A),
               .MAXW_B(MAXW_B), .SET_A(SET_A), .SET_B(SET_B), .SCK_HALF(SCK_HALF),
               .DONE_CHECK(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial), .profile_i(profile),
    .msb_first_i(msbf), .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last),
    .s_ready_o(s_ready), .tgt_stat_n_i(stat_n), .tgt_done_i(done_pin),
    .tgt_cfg_n_o(cfg_n), .sdata_o(sdata), .sclk_o(sclk), .busy_o(busy),
    .done_o(done_f), .err_o(err));

  int total = 0, bad = 0;
  logic [7:0] byt[$];

  // target model
  int tmode = M_REL, rel_at = 11, since = 0;
  logic nstat = 1'b1;
  assign stat_n = nstat;
  always @(negedge clk) begin
    if (tmode == M_STUCK) nstat <= 1'b1;
    else if (!cfg_n) begin nstat <= 1'b0; since <= 0; end
    else begin
      since <= since + 1;
      if ((tmode == M_REL || tmode == M_CERR) && since + 1 == rel_at) nstat <= 1'b1;
      if (tmode == M_CERR && sclk) nstat <= 1'b0;
    end
  end

  // per-clock monitor
  int run_id = 0, seen_id = 0, cyc = 0;
  int cfg_low, t_rise, t_sck, t_idle, hi_run, hi_bad, stab_bad, idle_bad;
  bit cap[$];
  logic p_cfg = 1, p_sclk = 0, p_sd = 0, p_busy = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (run_id != seen_id) begin
      seen_id = run_id;
      cap.delete();
      cfg_low = 0; t_rise = -1; t_sck = -1; t_idle = -1;
      hi_run = 0; hi_bad = 0; stab_bad = 0; idle_bad = 0;
    end else if (rst_n) begin
      if (!cfg_n) cfg_low++;
      if (cfg_n && !p_cfg && t_rise < 0) t_rise = cyc;
      if (sclk && !p_sclk) begin cap.push_back(sdata); if (t_sck < 0) t_sck = cyc; end
      if (sclk) hi_run++;
      else begin if (p_sclk && hi_run != SCK_HALF) hi_bad++; hi_run = 0; end
      if (sclk && p_sclk && sdata != p_sd) stab_bad++;
      if (!busy && p_busy && t_idle < 0) t_idle = cyc;
      if (!busy && (sclk || !cfg_n || s_ready)) idle_bad++;
    end
    p_cfg = cfg_n; p_sclk = sclk; p_sd = sdata; p_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = b[k];
    return r;
  endfunction

  task automatic feed(input int n);
    int i;
    i = 0;
    s_valid = 1'b1; s_data = byt[0]; s_last = (n == 1);
    while (i < n) begin
      @(negedge clk);
      if (!busy) break;
      if (s_ready) begin
        i++;
        @(negedge clk);
        if (i < n) begin s_data = byt[i]; s_last = (i == n - 1); end
        else s_valid = 1'b0;
      end
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  logic [2:0] err_at_start;
  logic done_at_start;
  task automatic run(input bit prof, input bit msb, input bit part, input int tm,
                     input int rel, input bit dpin);
    tmode = tm; rel_at = rel; done_pin = dpin;
    run_id++;
    @(negedge clk); @(negedge clk);
    start = 1; partial = part; profile = prof; msbf = msb;
    @(negedge clk);
    start = 0; partial = 0;
    err_at_start = err; done_at_start = done_f;
    if (busy) fork feed(byt.size()); wait_idle(); join
    else repeat (6) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_stream(input bit msb, input bit trailer, input string tag);
    logic [7:0] v;
    int n, mism;
    n = byt.size() * 8 + (trailer ? 8 : 0);
    mism = 0;
    chk(cap.size() == n, {tag, " bit count"}, cap.size(), n);
    for (int i = 0; i < byt.size(); i++) begin
      v = msb ? rev8(byt[i]) : byt[i];
      for (int k = 0; k < 8; k++)
        if (i * 8 + k < cap.size() && cap[i * 8 + k] != v[k]) mism++;
    end
    if (trailer)
      for (int k = 0; k < 8; k++)
        if (byt.size() * 8 + k < cap.size() && cap[byt.size() * 8 + k] != 1'b0) mism++;
    chk(mism == 0, {tag, " bit values"}, mism, 0);
  endtask

  task automatic chk_clock_shape();
    chk(hi_bad == 0, "R6 clock high width", hi_bad, 0);
    chk(stab_bad == 0, "R6 data stable while clock high", stab_bad, 0);
    chk(idle_bad == 0, "R10 idle pins quiet", idle_bad, 0);
  endtask

  bit wd = 0;
  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(cfg_n == 1'b1 && sclk == 1'b0, "R1 reset pins", {cfg_n, sclk}, 2);
        chk(busy == 0 && s_ready == 0, "R10 reset idle", {busy, s_ready}, 0);
        chk(err == 0 && done_f == 0, "R11 reset status", {done_f, err}, 0);

        // success, profile 0, LSB-first
        byt = '{8'hA5, 8'h3C, 8'h01};
        run(0, 0, 0, M_REL, 11, 1);
        chk(cfg_low == RST_US * CYC_US, "R1 pulse length", cfg_low, RST_US * CYC_US);
        chk(t_sck - t_rise == POLL_US * CYC_US + SET_A * CYC_US + 1 + SCK_HALF,
            "R4 first edge profile 0", t_sck - t_rise, POLL_US * CYC_US + SET_A * CYC_US + 1 + SCK_HALF);
        chk_stream(0, 1, "R5 lsb first");
        chk(done_f == 1 && err == 0, "R9 done after trailer", {done_f, err}, 8);
        chk_clock_shape();

        // success, profile 1, reversed bytes, late release
        byt = '{8'h80, 8'h0F, 8'hC6, 8'h5A};
        run(1, 1, 0, M_REL, 31, 1);
        chk(done_at_start == 0, "R11 done cleared by start", done_at_start, 0);
        chk(t_sck - t_rise == 2 * POLL_US * CYC_US + SET_B * CYC_US + 1 + SCK_HALF,
            "R4 first edge profile 1", t_sck - t_rise, 2 * POLL_US * CYC_US + SET_B * CYC_US + 1 + SCK_HALF);
        chk_stream(1, 1, "R5 msb-first reversal");
        chk(done_f == 1 && err == 0, "R9 done profile 1", {done_f, err}, 8);
        chk_clock_shape();

        // partial request rejected
        run(0, 0, 1, M_REL, 11, 1);
        chk(err == 3'd1, "R10 partial error code", err, 1);
        chk(cfg_low == 0 && cap.size() == 0 && t_idle < 0, "R10 pins untouched",
            cfg_low + cap.size(), 0);
        chk(done_f == 0, "R11 done cleared by rejected start", done_f, 0);

        // no reset seen
        run(0, 0, 0, M_STUCK, 11, 1);
        chk(err == 3'd2, "R2 error code", err, 2);
        chk(cap.size() == 0, "R2 no clocks", cap.size(), 0);
        chk(cfg_low == RST_US * CYC_US, "R1 pulse before abort", cfg_low, RST_US * CYC_US);

        // not ready, both profiles
        run(0, 0, 0, M_NEVER, 0, 1);
        chk(err == 3'd3, "R3 error code profile 0", err, 3);
        chk(t_idle - t_rise == ((MAXW_A + POLL_US - 1) / POLL_US) * POLL_US * CYC_US,
            "R3 poll window profile 0", t_idle - t_rise, ((MAXW_A + POLL_US - 1) / POLL_US) * POLL_US * CYC_US);
        run(1, 0, 0, M_NEVER, 0, 1);
        chk(err == 3'd3, "R3 error code profile 1", err, 3);
        chk(t_idle - t_rise == ((MAXW_B + POLL_US - 1) / POLL_US) * POLL_US * CYC_US,
            "R3 poll window profile 1", t_idle - t_rise, ((MAXW_B + POLL_US - 1) / POLL_US) * POLL_US * CYC_US);
        chk(cap.size() == 0, "R3 no clocks", cap.size(), 0);

        // status asserted again after data
        byt = '{8'h11, 8'h22};
        run(0, 0, 0, M_CERR, 11, 1);
        chk(err == 3'd4, "R7 error code", err, 4);
        chk_stream(0, 0, "R7 no trailer");

        // done pin inactive
        byt = '{8'h7E, 8'h81, 8'h33};
        run(1, 0, 0, M_REL, 11, 0);
        chk(err == 3'd5, "R8 error code", err, 5);
        chk_stream(0, 0, "R8 no trailer");
        repeat (20) @(negedge clk);
        chk(err == 3'd5 && done_f == 0, "R11 error held while idle", err, 5);

        // recovery after error
        byt = '{8'hFF};
        run(0, 1, 0, M_REL, 11, 1);
        chk(err_at_start == 3'd0, "R11 error cleared by start", err_at_start, 0);
        chk_stream(1, 1, "R9 single byte with trailer");
        chk(done_f == 1 && err == 0, "R9 done after recovery", {done_f, err}, 8);
        chk_clock_shape();
      end
      begin
        repeat (LIMIT) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule